// File: doc/BRIEF.md
# Configuration Image Shadow Loader with Checksum Unit

This block sits between on-chip logic and the word-wide request port of a serial configuration memory controller. Once reset is released, and again whenever asked, it fetches all 64 sixteen-bit words of the device into a local shadow array. While it fetches, it adds them into a 16-bit wraparound sum. At the end it judges whether the image can be trusted. Two tests must pass: the sum must match the target constant, and a masked signature field in one configuration word must hold the expected pattern.

Consumers read configuration words through a lookup port. A lookup against a trusted image is answered from the shadow array with no device traffic. A lookup against an untrusted image first triggers a full reload and is then answered. The answer is zero if the image is still untrusted or if the index lies past the end of the device.

The block also carries two write operations. A plain word write sends one word to the device. A checksum repair reads words 0 to 62 and writes the corrected word to address 63. Either write marks the cached image as stale.

Top module: `eeimg_loader`

## Requirements
- R1: A load reads device addresses 0 to 63 in ascending order, one request per word. A load runs automatically from reset (`loading` is high while reset is held) and again on a `loadStart` pulse. `loading` stays high until the last word is accepted, and `opDone` pulses for one cycle at the end.
- R2: After a load, `checksumOk` is 1 exactly when the 16-bit wraparound sum of the 64 words read equals 16'hBABA.
- R3: A `updStart` pulse reads addresses 0 to 62, then writes (16'hBABA minus their 16-bit sum) modulo 2^16 to address 63, then pulses `opDone`.
- R4: `signatureOk` is 1 exactly when the cached word at index 10, ANDed with 16'hC000, equals 16'h4000. `imageValid` is high only when `checksumOk` and `signatureOk` are both high.
- R5: When a load ends with a bad sum, the bits under mask 16'hC000 in cached word 10 are cleared, so `signatureOk` reads 0 even if the device holds a good signature.
- R6: A lookup with `lkIdx` below 64 while `imageValid` is high is answered from the cache with no device request. `lkDone` pulses for exactly one cycle, carrying the word in `lkData`.
- R7: A lookup with `lkIdx` from 64 to 127 returns zero with no device request. A lookup below 64 while the image is invalid first performs a full 64-word reload. It then returns the word if the image became valid, and zero otherwise.
- R8: Every device write, whether a plain write or a checksum repair, clears the signature bits of cached word 10. `signatureOk` and `imageValid` are therefore 0 from the cycle after the write is accepted.
- R9: Commands are accepted only while the block is idle. When several arrive in the same cycle, a write (`wrStart`) beats a checksum repair, which beats a load, which beats a lookup.
- R10: Once `memReq` is raised, it stays high with `memAddr`, `memWe` and `memWdata` unchanged until the cycle in which `memAck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStart | input | 1 | Pulse: reload the whole image |
| updStart | input | 1 | Pulse: recompute and write the checksum word |
| wrStart | input | 1 | Pulse: write `wrData` to device address `wrAddr` |
| wrAddr | input | 6 | Word address for a plain write |
| wrData | input | 16 | Data for a plain write |
| lkReq | input | 1 | Pulse: look up word `lkIdx` |
| lkIdx | input | 7 | Lookup index; 64 and above are out of range |
| lkDone | output | 1 | One-cycle pulse: `lkData` holds the answer |
| lkData | output | 16 | Lookup answer |
| memReq | output | 1 | Request to the device controller |
| memWe | output | 1 | 1 = write request, 0 = read request |
| memAddr | output | 6 | Request word address |
| memWdata | output | 16 | Request write data |
| memAck | input | 1 | Controller completes the current request |
| memRdata | input | 16 | Read data, valid with `memAck` on a read |
| loading | output | 1 | High while an image load is reading the device |
| imageValid | output | 1 | Cached image is trusted |
| checksumOk | output | 1 | Sum of the last load matched the target |
| signatureOk | output | 1 | Cached signature field matches |
| opDone | output | 1 | One-cycle pulse at the end of a load, repair or write |

## Verification
The checks rest on these assumptions about the environment:
- `memAck` rises only while `memReq` is high, and it lasts one cycle.
- Commands are issued only while the block is idle.
- At most one command is pulsed at a time, apart from a deliberate priority collision.

The bench's device model follows these rules. It acknowledges after a random wait of zero to two cycles, and it drops `memAck` in the cycle after it raises it. The sequencing code issues each command as a single pulse and then waits for `opDone` or `lkDone` before sending the next. Random images are drawn as valid, bad-sum or bad-signature, so every outcome of the validity test is reached under the same assumptions.

// File: rtl/eeimg_pkg.sv
package eeimg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_EVAL,
    S_SUMRD,
    S_FIXWR,
    S_WRITE,
    S_RESP
  } eeState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrAcc;    // zero the address counter and the running sum
    logic loadWord;  // store read data in the shadow array and add it to the sum
    logic sumWord;   // add read data to the sum only
    logic stepAddr;  // advance the address counter
    logic mkFix;     // form the corrected checksum word
    logic capWr;     // capture user write address and data
    logic evalSum;   // judge the finished sum
    logic killSig;   // clear the cached signature after a write
    logic capIdx;    // capture the lookup index
    logic respond;   // produce the lookup answer
  } ctrlStrb_t;

endpackage

// File: rtl/eeimg_ctrl.sv
module eeimg_ctrl
  import eeimg_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadStart,
  input  logic          updStart,
  input  logic          wrStart,
  input  logic          lkReq,
  input  logic [AW:0]   lkIdx,
  input  logic          imageValid,
  input  logic          memAck,
  input  logic [AW-1:0] addrCur,
  output ctrlStrb_t     strb,
  output logic          memReq,
  output logic          memWe,
  output logic          loading,
  output logic          opDone
);

  localparam logic [AW:0]   LIMIT  = (AW+1)'(WORDS);
  localparam logic [AW-1:0] LAST   = AW'(WORDS - 1);
  localparam logic [AW-1:0] PENULT = AW'(WORDS - 2);

  eeState_t st, nxt;
  logic     pend;
  logic     setPend;

  always_comb begin
    strb    = '0;
    nxt     = st;
    setPend = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (wrStart) begin
          strb.capWr = 1'b1;
          nxt        = S_WRITE;
        end else if (updStart) begin
          strb.clrAcc = 1'b1;
          nxt         = S_SUMRD;
        end else if (loadStart) begin
          strb.clrAcc = 1'b1;
          nxt         = S_LOAD;
        end else if (lkReq) begin
          strb.capIdx = 1'b1;
          if (imageValid || (lkIdx >= LIMIT)) begin
            nxt = S_RESP;
          end else begin
            strb.clrAcc = 1'b1;
            setPend     = 1'b1;
            nxt         = S_LOAD;
          end
        end
      end
      S_LOAD: begin
        if (memAck) begin
          strb.loadWord = 1'b1;
          strb.stepAddr = 1'b1;
          if (addrCur == LAST) nxt = S_EVAL;
        end
      end
      S_EVAL: begin
        strb.evalSum = 1'b1;
        nxt          = pend ? S_RESP : S_IDLE;
      end
      S_SUMRD: begin
        if (memAck) begin
          strb.sumWord  = 1'b1;
          strb.stepAddr = 1'b1;
          if (addrCur == PENULT) begin
            strb.mkFix = 1'b1;
            nxt        = S_FIXWR;
          end
        end
      end
      S_FIXWR, S_WRITE: begin
        if (memAck) begin
          strb.killSig = 1'b1;
          nxt          = S_IDLE;
        end
      end
      S_RESP: begin
        strb.respond = 1'b1;
        nxt          = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= S_LOAD;
      pend   <= 1'b0;
      opDone <= 1'b0;
    end else begin
      st     <= nxt;
      opDone <= (st == S_EVAL) ||
                (((st == S_FIXWR) || (st == S_WRITE)) && memAck);
      if (setPend)            pend <= 1'b1;
      else if (st == S_RESP)  pend <= 1'b0;
    end
  end

  assign memReq  = (st == S_LOAD) || (st == S_SUMRD) ||
                   (st == S_FIXWR) || (st == S_WRITE);
  assign memWe   = (st == S_FIXWR) || (st == S_WRITE);
  assign loading = (st == S_LOAD);

endmodule

// File: rtl/eeimg_dp.sv
module eeimg_dp
  import eeimg_pkg::*;
#(
  parameter int            WORDS      = 64,
  parameter int            DW         = 16,
  parameter int            AW         = $clog2(WORDS),
  parameter logic [DW-1:0] SUM_TARGET = 16'hBABA,
  parameter int            SIG_IDX    = 10,
  parameter logic [DW-1:0] SIG_MASK   = 16'hC000,
  parameter logic [DW-1:0] SIG_VALUE  = 16'h4000
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrb_t     strb,
  input  logic [DW-1:0] memRdata,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW:0]   lkIdx,
  output logic [AW-1:0] addrCur,
  output logic [DW-1:0] wdCur,
  output logic          checksumOk,
  output logic          signatureOk,
  output logic          imageValid,
  output logic          lkDone,
  output logic [DW-1:0] lkData
);

  localparam logic [AW:0] LIMIT = (AW+1)'(WORDS);

  logic [DW-1:0] shadow [WORDS];
  logic [DW-1:0] acc;
  logic [DW-1:0] accNext;
  logic [AW:0]   idxReg;
  logic          sumBad;

  assign accNext = acc + memRdata;
  assign sumBad  = (acc != SUM_TARGET);

  // one register per cached word; the signature word also takes the clears
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    if (g == SIG_IDX) begin : g_sig
      always_ff @(posedge clk) begin
        if (!rstN)
          shadow[g] <= '0;
        else if (strb.loadWord && (addrCur == AW'(g)))
          shadow[g] <= memRdata;
        else if (strb.killSig || (strb.evalSum && sumBad))
          shadow[g] <= shadow[g] & ~SIG_MASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)
          shadow[g] <= '0;
        else if (strb.loadWord && (addrCur == AW'(g)))
          shadow[g] <= memRdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc        <= '0;
      addrCur    <= '0;
      wdCur      <= '0;
      checksumOk <= 1'b0;
      idxReg     <= '0;
      lkDone     <= 1'b0;
      lkData     <= '0;
    end else begin
      if (strb.clrAcc)                        acc <= '0;
      else if (strb.loadWord || strb.sumWord) acc <= accNext;

      if (strb.clrAcc)        addrCur <= '0;
      else if (strb.capWr)    addrCur <= wrAddr;
      else if (strb.stepAddr) addrCur <= addrCur + 1'b1;

      if (strb.capWr)      wdCur <= wrData;
      else if (strb.mkFix) wdCur <= SUM_TARGET - accNext;

      if (strb.evalSum) checksumOk <= !sumBad;
      if (strb.capIdx)  idxReg     <= lkIdx;

      lkDone <= strb.respond;
      if (strb.respond)
        lkData <= (imageValid && (idxReg < LIMIT)) ? shadow[idxReg[AW-1:0]] : '0;
    end
  end

  assign signatureOk = ((shadow[SIG_IDX] & SIG_MASK) == SIG_VALUE);
  assign imageValid  = checksumOk && signatureOk;

endmodule

// File: rtl/eeimg_loader.sv
module eeimg_loader
  import eeimg_pkg::*;
#(
  parameter int            WORDS      = 64,
  parameter int            DW         = 16,
  parameter int            AW         = $clog2(WORDS),
  parameter logic [DW-1:0] SUM_TARGET = 16'hBABA,
  parameter int            SIG_IDX    = 10,
  parameter logic [DW-1:0] SIG_MASK   = 16'hC000,
  parameter logic [DW-1:0] SIG_VALUE  = 16'h4000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadStart,
  input  logic          updStart,
  input  logic          wrStart,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          lkReq,
  input  logic [AW:0]   lkIdx,
  output logic          lkDone,
  output logic [DW-1:0] lkData,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memAck,
  input  logic [DW-1:0] memRdata,
  output logic          loading,
  output logic          imageValid,
  output logic          checksumOk,
  output logic          signatureOk,
  output logic          opDone
);

  ctrlStrb_t strb;

  eeimg_ctrl #(.WORDS(WORDS), .AW(AW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .loadStart(loadStart), .updStart(updStart), .wrStart(wrStart),
    .lkReq(lkReq), .lkIdx(lkIdx), .imageValid(imageValid),
    .memAck(memAck), .addrCur(memAddr),
    .strb(strb), .memReq(memReq), .memWe(memWe),
    .loading(loading), .opDone(opDone)
  );

  eeimg_dp #(
    .WORDS(WORDS), .DW(DW), .AW(AW), .SUM_TARGET(SUM_TARGET),
    .SIG_IDX(SIG_IDX), .SIG_MASK(SIG_MASK), .SIG_VALUE(SIG_VALUE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .memRdata(memRdata),
    .wrAddr(wrAddr), .wrData(wrData), .lkIdx(lkIdx),
    .addrCur(memAddr), .wdCur(memWdata),
    .checksumOk(checksumOk), .signatureOk(signatureOk), .imageValid(imageValid),
    .lkDone(lkDone), .lkData(lkData)
  );

endmodule

// File: rtl/eeimg_loader_chk.sv
module eeimg_loader_chk #(
  parameter int WORDS = 64,
  parameter int DW    = 16,
  parameter int AW    = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rstN,
  input logic          memReq,
  input logic          memWe,
  input logic          memAck,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memWdata,
  input logic          loading,
  input logic          signatureOk,
  input logic          imageValid,
  input logic          lkDone,
  input logic [DW-1:0] lkData
);

  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R1
  load_ascend_chk: assert property (@(posedge clk) disable iff (!rstN)
    loading && memAck && (memAddr != LAST) |=> loading && (memAddr == $past(memAddr) + 1'b1));

  // R8
  write_kills_sig_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck |=> !signatureOk && !imageValid);

  // R6
  lk_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkDone |=> !lkDone);

  // R7
  lk_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkDone && !imageValid |-> lkData == '0);

endmodule

bind eeimg_loader eeimg_loader_chk #(.WORDS(WORDS), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .memWdata(memWdata), .loading(loading),
  .signatureOk(signatureOk), .imageValid(imageValid),
  .lkDone(lkDone), .lkData(lkData)
);

// File: tb/eeimg_loader_tb_top.sv
module eeimg_loader_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        loadStart, updStart, wrStart, lkReq;
  logic [5:0]  wrAddr;
  logic [15:0] wrData;
  logic [6:0]  lkIdx;
  logic        lkDone;
  logic [15:0] lkData;
  logic        memReq, memWe, memAck;
  logic [5:0]  memAddr;
  logic [15:0] memWdata, memRdata;
  logic        loading, imageValid, checksumOk, signatureOk, opDone;

  always #5 clk = ~clk;

  eeimg_loader dut_i (
    .clk(clk), .rstN(rstN), .loadStart(loadStart), .updStart(updStart),
    .wrStart(wrStart), .wrAddr(wrAddr), .wrData(wrData), .lkReq(lkReq),
    .lkIdx(lkIdx), .lkDone(lkDone), .lkData(lkData), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .loading(loading), .imageValid(imageValid),
    .checksumOk(checksumOk), .signatureOk(signatureOk), .opDone(opDone)
  );

  // device model state
  logic [15:0] rom [64];
  int          rdCount = 0, wrCount = 0, orderBad = 0;
  logic [5:0]  prevRd = '0, lastWrAddr = '0, pAddr = '0;
  logic [15:0] lastWrData = '0, pData = '0;
  logic        pWe = 1'b0;
  int          waitCnt = 0;
  int          nChk = 0, nBad = 0;

  // device model: acknowledges after 0..2 idle cycles, applies writes after ack
  initial begin
    memAck = 1'b0; memRdata = '0;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        memAck = 1'b0; waitCnt = 0;
      end else if (memAck) begin
        if (pWe) begin
          rom[pAddr] = pData; wrCount++; lastWrAddr = pAddr; lastWrData = pData;
        end
        memAck = 1'b0;
      end else if (memReq) begin
        if (waitCnt > 0) waitCnt--;
        else begin
          memAck = 1'b1; pWe = memWe; pAddr = memAddr; pData = memWdata;
          if (!memWe) begin
            memRdata = rom[memAddr];
            if (memAddr != 6'd0 && memAddr != prevRd + 6'd1) orderBad++;
            prevRd = memAddr; rdCount++;
          end
          waitCnt = int'($urandom % 3);
        end
      end
    end
  end

  function automatic logic [15:0] romSum(int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s += rom[i];
    return s;
  endfunction

  function automatic bit romSigOk();
    return (rom[10] & 16'hC000) == 16'h4000;
  endfunction

  function automatic bit romValid();
    return (romSum(64) == 16'hBABA) && romSigOk();
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mkImage(input bit sigGood, input bit sumGood);
    for (int i = 0; i < 64; i++) rom[i] = 16'($urandom);
    rom[10] = (rom[10] & 16'h3FFF) | (sigGood ? 16'h4000 : 16'h8000);
    rom[63] = 16'hBABA - romSum(63);
    if (!sumGood) rom[63] = rom[63] + 16'd1 + 16'($urandom % 100);
  endtask

  task automatic waitDone();
    while (!opDone) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doLoad();
    @(negedge clk); loadStart = 1'b1;
    @(negedge clk); loadStart = 1'b0;
    waitDone();
  endtask

  task automatic doLookup(input logic [6:0] idx, output logic [15:0] val);
    @(negedge clk); lkReq = 1'b1; lkIdx = idx;
    @(negedge clk); lkReq = 1'b0;
    while (!lkDone) @(negedge clk);
    val = lkData;
  endtask

  task automatic checkStatus(input string tag);
    bit sumOk;
    sumOk = (romSum(64) == 16'hBABA);
    chk(checksumOk == sumOk, {tag, " R2 checksumOk"}, 32'(checksumOk), 32'(sumOk));
    chk(signatureOk == (sumOk && romSigOk()), {tag, " R5 signatureOk"},
        32'(signatureOk), 32'(sumOk && romSigOk()));
    chk(imageValid == romValid(), {tag, " R4 imageValid"}, 32'(imageValid), 32'(romValid()));
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int          r0, w0;
    logic [15:0] v, ex;
    void'($urandom(32'd4242));
    rstN = 1'b0; loadStart = 0; updStart = 0; wrStart = 0; lkReq = 0;
    wrAddr = '0; wrData = '0; lkIdx = '0;
    mkImage(1, 1);
    repeat (3) @(negedge clk);
    // reset state (R1: auto load pending, nothing valid)
    chk(loading == 1'b1, "R1 reset loading", 32'(loading), 1);
    chk(imageValid == 1'b0, "R4 reset imageValid", 32'(imageValid), 0);
    chk(lkDone == 1'b0 && opDone == 1'b0, "R6 reset pulses", 32'({lkDone, opDone}), 0);
    rstN = 1'b1;
    r0 = rdCount;
    waitDone();
    chk(rdCount - r0 == 64, "R1 auto load reads", 32'(rdCount - r0), 64);
    chk(orderBad == 0, "R1 ascending order", 32'(orderBad), 0);
    chk(loading == 1'b0, "R1 loading low after", 32'(loading), 0);
    checkStatus("auto");

    // cached lookups
    r0 = rdCount;
    foreach (rom[i]) if (i == 0 || i == 10 || i == 63) begin
      doLookup(7'(i), v);
      chk(v == rom[i], "R6 cached word", 32'(v), 32'(rom[i]));
    end
    doLookup(7'd64, v);  chk(v == 16'h0, "R7 index 64", 32'(v), 0);
    doLookup(7'd127, v); chk(v == 16'h0, "R7 index 127", 32'(v), 0);
    chk(rdCount == r0, "R6 no device reads", 32'(rdCount - r0), 0);

    // bad sum with good stored signature
    rom[5] = rom[5] ^ 16'h0001;
    doLoad();
    checkStatus("badsum");
    chk(signatureOk == 1'b0, "R5 sig cleared", 32'(signatureOk), 0);
    r0 = rdCount;
    doLookup(7'd3, v);
    chk(rdCount - r0 == 64, "R7 invalid lookup reloads", 32'(rdCount - r0), 64);
    chk(v == 16'h0, "R7 invalid lookup zero", 32'(v), 0);

    // checksum repair
    r0 = rdCount; w0 = wrCount;
    ex = 16'hBABA - romSum(63);
    @(negedge clk); updStart = 1'b1;
    @(negedge clk); updStart = 1'b0;
    waitDone();
    chk(rdCount - r0 == 63, "R3 repair reads", 32'(rdCount - r0), 63);
    chk(wrCount - w0 == 1 && lastWrAddr == 6'd63, "R3 repair write addr",
        32'(lastWrAddr), 63);
    chk(lastWrData == ex, "R3 repair value", 32'(lastWrData), 32'(ex));
    chk(imageValid == 1'b0 && signatureOk == 1'b0, "R8 repair invalidates",
        32'({imageValid, signatureOk}), 0);
    r0 = rdCount;
    doLookup(7'd7, v);
    chk(rdCount - r0 == 64 && v == rom[7], "R7 reload after repair", 32'(v), 32'(rom[7]));
    chk(imageValid == 1'b1, "R4 valid after repair", 32'(imageValid), 1);

    // good sum, bad signature
    mkImage(0, 1);
    doLoad();
    checkStatus("badsig");
    chk(checksumOk == 1'b1 && imageValid == 1'b0, "R4 sig reject",
        32'({checksumOk, imageValid}), 32'(2'b10));

    // write with simultaneous load: write wins (R9), then invalidates (R8)
    mkImage(1, 1);
    doLoad();
    r0 = rdCount; w0 = wrCount;
    @(negedge clk); wrStart = 1'b1; loadStart = 1'b1; wrAddr = 6'd20; wrData = 16'h1234;
    @(negedge clk); wrStart = 1'b0; loadStart = 1'b0;
    waitDone();
    chk(rdCount == r0 && wrCount - w0 == 1, "R9 write beats load",
        32'(rdCount - r0), 0);
    chk(rom[20] == 16'h1234, "R9 write data", 32'(rom[20]), 32'h1234);
    chk(imageValid == 1'b0, "R8 write invalidates", 32'(imageValid), 0);
    doLookup(7'd20, v);
    ex = romValid() ? rom[20] : 16'h0;
    chk(v == ex, "R7 lookup after write", 32'(v), 32'(ex));

    // random rounds
    for (int k = 0; k < 25; k++) begin
      int kind = int'($urandom % 3);
      mkImage(kind != 2, kind != 1);
      doLoad();
      checkStatus("rand");
      for (int j = 0; j < 4; j++) begin
        logic [6:0] idx = 7'($urandom);
        doLookup(idx, v);
        ex = (idx < 7'd64 && romValid()) ? rom[idx[5:0]] : 16'h0;
        chk(v == ex, "R6 R7 random lookup", 32'(v), 32'(ex));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule